// File: doc/BRIEF.md
# Firmware Download Session Tracker

This block is the device-side bookkeeping for loading new firmware into a managed flash device while it sits in the field. The host writes a mode byte to switch the device between normal operation and a download session. A session can only start when a capability input says the device supports it. While the session is open, every data write command is screened. Its argument must equal a fixed download argument and its block length must equal the data sector size. Any violation marks the session as failed.

Each sector that the programming logic reports as done is counted. The count is a readable register. When it is zero, the host starts the image from the beginning. When it is nonzero, the host resumes at the sector after the counted ones. The image length is given in whole sectors.

Some events end a session before the image is complete: leaving download mode, a device reset (CMD0 or the hardware reset pin) or a power cycle. Each of these aborts the session. The host chooses whether the partial image is discarded, which clears the count, or kept for a later resume.

A session is clean when the count has reached the image length and no error was recorded. When a clean session is left and the device has no operation-code mechanism, an install is armed. The next device reset then raises a one-cycle install request.

Top module: `fw_dl_tracker`

## Requirements
- R1: After power-on reset (`rstN` low), `dlMode`, `dlError` and `installReq` are 0 and `sectorCount` is 0.
- R2: A mode write of value 0x01 enters download mode only when `featureSupported` is 1. A mode write of 0x00 leaves download mode. Any other value, or a write while the feature is unsupported, leaves the mode unchanged.
- R3: In download mode, a `cmdValid` whose `cmdArg` differs from `DL_ARG`, or whose `cmdBlkLen` differs from `SECTOR_BYTES`, sets `dlError`. `dlError` stays set until download mode is next entered, where it clears. Commands in normal mode never set it.
- R4: In download mode with `dlError` clear, each `sectorDone` pulse adds one to `sectorCount`. In normal mode or with `dlError` set, `sectorDone` has no effect.
- R5: Entering download mode keeps `sectorCount`, so a session can resume. A session is clean when `imageSectors` > 0, `sectorCount` >= `imageSectors` and `dlError` = 0. An aborting exit is a mode write of 0x00 or a `devResetReq` while the session is not clean. An aborting exit clears `sectorCount` only when `discardPartial` is 1; otherwise the count is held.
- R6: A mode write of 0x00 from a clean session with `opCodesSupported` = 0 arms an install. The next `devResetReq` drives `installReq` high for exactly one cycle and clears `sectorCount`. Entering download mode again disarms the install.
- R7: When `opCodesSupported` is 1, a clean exit arms no install and keeps `sectorCount`. A later `devResetReq` gives no `installReq`.
- R8: `sectorCount` saturates at its maximum value (all ones); further sectors leave it there.
- R9: `devResetReq` always returns the block to normal mode.
- R10: Priority within one cycle is `devResetReq`, then the mode write, then command and sector strobes. Every output reflects a strobe on the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| featureSupported | input | 1 | Capability bit: firmware download supported |
| opCodesSupported | input | 1 | Capability bit: install is driven by operation codes, not by reset |
| discardPartial | input | 1 | 1 = an aborted partial image is discarded (count clears) |
| modeWrEn | input | 1 | Write strobe for the mode byte |
| modeWrData | input | MODE_W | Mode byte value (0x00 normal, 0x01 download) |
| cmdValid | input | 1 | Data write command strobe |
| cmdArg | input | ARG_W | Argument of the data command |
| cmdBlkLen | input | LEN_W | Block length of the data command, bytes |
| sectorDone | input | 1 | Pulse: one sector programmed correctly |
| devResetReq | input | 1 | Pulse: CMD0 or hardware reset seen |
| imageSectors | input | CNT_W | Firmware bundle length in sectors |
| dlMode | output | 1 | 1 while in download mode |
| sectorCount | output | CNT_W | Count of correctly programmed sectors |
| dlError | output | 1 | Sticky download failure flag |
| installReq | output | 1 | One-cycle install request |

## Verification
Every result is registered once. The mode, error flag, count and install pulse driven by a strobe are all due on the first clock edge after the strobe is sampled. The bench drives inputs on the falling edge and lets one rising edge pass. It compares every output on the next falling edge against its own model, so each comparison lands one cycle after its stimulus. For the install request, the bench also checks on the following falling edge that the pulse has dropped.

// File: rtl/fw_dl_pkg.sv
package fw_dl_pkg;

  localparam logic [7:0] MODE_NORMAL   = 8'h00;
  localparam logic [7:0] MODE_DOWNLOAD = 8'h01;

  typedef struct packed {
    logic incCnt;
    logic clrCnt;
    logic setErr;
    logic clrErr;
  } dlStrobes_t;

endpackage

// File: rtl/fw_dl_datapath.sv
module fw_dl_datapath
  import fw_dl_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int ARG_W        = 32,
  parameter int LEN_W        = 16,
  parameter logic [ARG_W-1:0] DL_ARG = 32'hFF00_F0F0,
  parameter int SECTOR_BYTES = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  dlStrobes_t       strobes,
  input  logic [ARG_W-1:0] cmdArg,
  input  logic [LEN_W-1:0] cmdBlkLen,
  input  logic [CNT_W-1:0] imageSectors,
  output logic             cmdMatch,
  output logic             bundleFull,
  output logic             errFlag,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [LEN_W-1:0] BLK_SIZE = LEN_W'(SECTOR_BYTES);

  logic atMax;

  assign atMax      = (count == CNT_MAX);
  assign cmdMatch   = (cmdArg == DL_ARG) && (cmdBlkLen == BLK_SIZE);
  assign bundleFull = (imageSectors != '0) && (count >= imageSectors);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.clrCnt) begin
      count <= '0;
    end else if (strobes.incCnt && !atMax) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strobes.clrErr) begin
      errFlag <= 1'b0;
    end else if (strobes.setErr) begin
      errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/fw_dl_ctrl.sv
module fw_dl_ctrl
  import fw_dl_pkg::*;
#(
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              featureSupported,
  input  logic              opCodesSupported,
  input  logic              discardPartial,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeWrData,
  input  logic              cmdValid,
  input  logic              sectorDone,
  input  logic              devResetReq,
  input  logic              cmdMatch,
  input  logic              bundleFull,
  input  logic              errFlag,
  output dlStrobes_t        strobes,
  output logic              dlMode,
  output logic              installReq
);

  logic modeNext, pendNext, instNext;
  logic installPending;
  logic wrEnter, wrLeave, sessionClean;

  assign wrEnter      = modeWrEn && (modeWrData == MODE_W'(MODE_DOWNLOAD))
                        && featureSupported && !dlMode;
  assign wrLeave      = modeWrEn && (modeWrData == MODE_W'(MODE_NORMAL)) && dlMode;
  assign sessionClean = bundleFull && !errFlag;

  always_comb begin
    strobes  = '0;
    modeNext = dlMode;
    pendNext = installPending;
    instNext = 1'b0;
    if (devResetReq) begin
      modeNext = 1'b0;
      if (installPending) begin
        instNext       = 1'b1;
        pendNext       = 1'b0;
        strobes.clrCnt = 1'b1;
      end else if (dlMode && !sessionClean && discardPartial) begin
        strobes.clrCnt = 1'b1;
      end
    end else if (wrEnter) begin
      modeNext       = 1'b1;
      pendNext       = 1'b0;
      strobes.clrErr = 1'b1;
    end else if (wrLeave) begin
      modeNext = 1'b0;
      if (sessionClean && !opCodesSupported) begin
        pendNext = 1'b1;
      end else if (!sessionClean && discardPartial) begin
        strobes.clrCnt = 1'b1;
      end
    end else if (dlMode) begin
      strobes.incCnt = sectorDone && !errFlag;
      strobes.setErr = cmdValid && !cmdMatch;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlMode         <= 1'b0;
      installPending <= 1'b0;
      installReq     <= 1'b0;
    end else begin
      dlMode         <= modeNext;
      installPending <= pendNext;
      installReq     <= instNext;
    end
  end

endmodule

// File: rtl/fw_dl_tracker.sv
module fw_dl_tracker
  import fw_dl_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int ARG_W        = 32,
  parameter int LEN_W        = 16,
  parameter int MODE_W       = 8,
  parameter logic [ARG_W-1:0] DL_ARG = 32'hFF00_F0F0,
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              featureSupported,
  input  logic              opCodesSupported,
  input  logic              discardPartial,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeWrData,
  input  logic              cmdValid,
  input  logic [ARG_W-1:0]  cmdArg,
  input  logic [LEN_W-1:0]  cmdBlkLen,
  input  logic              sectorDone,
  input  logic              devResetReq,
  input  logic [CNT_W-1:0]  imageSectors,
  output logic              dlMode,
  output logic [CNT_W-1:0]  sectorCount,
  output logic              dlError,
  output logic              installReq
);

  dlStrobes_t strobes;
  logic cmdMatch, bundleFull;

  fw_dl_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .featureSupported(featureSupported), .opCodesSupported(opCodesSupported),
    .discardPartial(discardPartial), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .cmdValid(cmdValid), .sectorDone(sectorDone), .devResetReq(devResetReq),
    .cmdMatch(cmdMatch), .bundleFull(bundleFull), .errFlag(dlError),
    .strobes(strobes), .dlMode(dlMode), .installReq(installReq)
  );

  fw_dl_datapath #(
    .CNT_W(CNT_W), .ARG_W(ARG_W), .LEN_W(LEN_W),
    .DL_ARG(DL_ARG), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cmdArg(cmdArg), .cmdBlkLen(cmdBlkLen), .imageSectors(imageSectors),
    .cmdMatch(cmdMatch), .bundleFull(bundleFull),
    .errFlag(dlError), .count(sectorCount)
  );

endmodule

// File: rtl/fw_dl_tracker_chk.sv
module fw_dl_tracker_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             featureSupported,
  input logic             sectorDone,
  input logic             devResetReq,
  input logic             dlMode,
  input logic [CNT_W-1:0] sectorCount,
  input logic             dlError,
  input logic             installReq
);

  // R6
  install_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    installReq |=> !installReq);

  // R6
  install_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    installReq |-> $past(devResetReq));

  // R3
  err_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dlError) |-> $past(dlMode));

  // R4
  count_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sectorCount != $past(sectorCount)) && (sectorCount != '0)
      |-> ($past(dlMode) && $past(sectorDone) && !$past(dlError)));

  // R2
  enter_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dlMode) |-> $past(featureSupported));

  // R9
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    devResetReq |=> !dlMode);

endmodule

bind fw_dl_tracker fw_dl_tracker_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/fw_dl_tracker_tb.sv
module fw_dl_tracker_tb;

  localparam int CW = 4;
  localparam logic [31:0] DLA = 32'hA5C3_0F01;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic featureSupported = 1'b1, opCodesSupported = 1'b0, discardPartial = 1'b0;
  logic modeWrEn = 1'b0;
  logic [7:0] modeWrData = '0;
  logic cmdValid = 1'b0;
  logic [31:0] cmdArg = DLA;
  logic [15:0] cmdBlkLen = 16'd512;
  logic sectorDone = 1'b0, devResetReq = 1'b0;
  logic [CW-1:0] imageSectors = 4'd3;
  logic dlMode, dlError, installReq;
  logic [CW-1:0] sectorCount;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  string tag = "R1";

  logic mMode = 0, mErr = 0, mPend = 0, mInst = 0;
  logic [CW-1:0] mCnt = '0;

  always #10 clk = ~clk;

  fw_dl_tracker #(.CNT_W(CW), .DL_ARG(DLA)) u_dut (
    .clk(clk), .rstN(rstN), .featureSupported(featureSupported),
    .opCodesSupported(opCodesSupported), .discardPartial(discardPartial),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .cmdValid(cmdValid),
    .cmdArg(cmdArg), .cmdBlkLen(cmdBlkLen), .sectorDone(sectorDone),
    .devResetReq(devResetReq), .imageSectors(imageSectors),
    .dlMode(dlMode), .sectorCount(sectorCount), .dlError(dlError),
    .installReq(installReq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    logic clean;
    logic nInst;
    clean = (imageSectors != 0) && (mCnt >= imageSectors) && !mErr;
    nInst = 0;
    if (devResetReq) begin
      if (mPend) begin nInst = 1; mCnt = '0; mPend = 0; end
      else if (mMode && !clean && discardPartial) mCnt = '0;
      mMode = 0;
    end else if (modeWrEn && modeWrData == 8'h01 && featureSupported && !mMode) begin
      mMode = 1; mErr = 0; mPend = 0;
    end else if (modeWrEn && modeWrData == 8'h00 && mMode) begin
      mMode = 0;
      if (clean && !opCodesSupported) mPend = 1;
      else if (!clean && discardPartial) mCnt = '0;
    end else if (mMode) begin
      if (sectorDone && !mErr && mCnt != CMAX) mCnt = mCnt + 1'b1;
      if (cmdValid && (cmdArg != DLA || cmdBlkLen != 16'd512)) mErr = 1;
    end
    mInst = nInst;
  endtask

  // one cycle: model, edge, compare on the falling edge, release strobes
  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2/R9 mode"}, 32'(dlMode), 32'(mMode));
    chk({tag, " R3 error"}, 32'(dlError), 32'(mErr));
    chk({tag, " R4 count"}, 32'(sectorCount), 32'(mCnt));
    chk({tag, " R6 install"}, 32'(installReq), 32'(mInst));
    modeWrEn = 0; cmdValid = 0; sectorDone = 0; devResetReq = 0;
    cmdArg = DLA; cmdBlkLen = 16'd512;
  endtask

  task automatic wrMode(input logic [7:0] v);
    modeWrEn = 1; modeWrData = v; step();
  endtask

  task automatic sectors(input int n);
    for (int i = 0; i < n; i++) begin
      cmdValid = 1; sectorDone = 1; step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(dlMode), 0);
    chk("R1 count", 32'(sectorCount), 0);
    chk("R1 error", 32'(dlError), 0);
    chk("R1 install", 32'(installReq), 0);
    rstN = 1;
    @(negedge clk);

    tag = "R2";
    featureSupported = 0; wrMode(8'h01);          // blocked: feature off
    featureSupported = 1; wrMode(8'h07);          // unknown value ignored
    wrMode(8'h01);                                // enter

    tag = "R4";
    sectorDone = 1; step();                       // count 1
    tag = "R10";
    sectorDone = 1; cmdValid = 1; step();         // count 2, one-cycle latency

    tag = "R3";
    cmdValid = 1; cmdArg = DLA ^ 32'h1; step();   // bad argument -> error
    sectors(2);                                   // ignored while error set
    wrMode(8'h00);                                // exit with error, keep count
    cmdValid = 1; cmdBlkLen = 16'd256; step();    // normal mode: ignored
    wrMode(8'h01);                                // error clears on entry

    tag = "R5";                                   // resume from held count
    cmdValid = 1; cmdBlkLen = 16'd1024; step();   // bad length -> error
    discardPartial = 1; wrMode(8'h00);            // abort + discard: count 0
    wrMode(8'h01);
    sectors(2);
    discardPartial = 0; devResetReq = 1; step();  // abort, count kept
    discardPartial = 1; wrMode(8'h01);
    devResetReq = 1; step();                      // abort, count cleared

    tag = "R6";
    discardPartial = 0; imageSectors = 4'd3;
    wrMode(8'h01);
    sectors(3);
    wrMode(8'h00);                                // clean exit arms install
    step(); step();
    devResetReq = 1; step();                      // installReq pulse, count 0
    step();                                       // pulse dropped

    tag = "R7";
    opCodesSupported = 1; wrMode(8'h01);
    sectors(3);
    wrMode(8'h00);
    devResetReq = 1; step();                      // no install, count held
    opCodesSupported = 0;

    tag = "R9";
    wrMode(8'h01);
    devResetReq = 1; modeWrEn = 1; modeWrData = 8'h01; step();  // reset wins

    tag = "R8";
    discardPartial = 0; imageSectors = 4'd0;
    wrMode(8'h01);
    sectors(20);                                  // saturates at 15
    wrMode(8'h00);
    discardPartial = 1; devResetReq = 1; step();

    tag = "RND";
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int p;
      p = $urandom_range(0, 99);
      if (i % 200 == 0) begin
        imageSectors = CW'($urandom_range(0, 6));
        discardPartial = $urandom_range(0, 1);
        opCodesSupported = ($urandom_range(0, 3) == 0);
        featureSupported = ($urandom_range(0, 7) != 0);
      end
      if (p < 3) devResetReq = 1;
      else if (p < 10) begin
        modeWrEn = 1;
        modeWrData = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'($urandom_range(0, 1));
      end else begin
        cmdValid = ($urandom_range(0, 1) == 1);
        sectorDone = ($urandom_range(0, 2) != 0);
        if ($urandom_range(0, 40) == 0) cmdArg = $urandom;
        if ($urandom_range(0, 40) == 0) cmdBlkLen = 16'($urandom_range(0, 1024));
      end
      step();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule